// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of interrupt request lines and routes them to several hart contexts. Every source has a small priority value. Every context has its own bit vector of enabled sources, its own threshold, and one external-interrupt output. A context's output is high while at least one source meets all of these conditions: it is pending, it is enabled for that context, and its priority is strictly above that context's threshold.

Software services an interrupt in two steps through a single per-context register. A read of that register claims the best deliverable source. It returns the source's identifier and clears its pending flag. Software later writes the same identifier back to mark the service complete. Until that write arrives, the source's gateway forwards no new request. Each gateway is fixed at build time as level-high or rising-edge triggered. Source identifier 0 is reserved and has no hardware behind it.

All registers sit on a simple 32-bit word bus. Read data returns one cycle after the request.

Top module: `plic_core`

## Requirements
- R1: Source 0 has no gateway and never becomes pending. Its priority reads 0 and its enable bit (bit 0 of word 0) reads 0. A claim read returns 0 when no source can be delivered to that context.
- R2: The priority of source ID sits at byte address 4*ID and holds 3 bits (bits 2:0). Bits 31:3 read 0 and writes to them are dropped.
- R3: The enable vector of context c starts at byte address 0x2000 + 0x80*c. The enable for source ID is bit (ID mod 32) of the 32-bit word at index (ID div 32) within that vector.
- R4: The control block of context c starts at byte address 0x200000 + 0x1000*c. The 3-bit threshold sits at offset 0x0 and the claim/complete register at offset 0x4.
- R5: Output irq_o[c] is high exactly when some source is pending, enabled for context c, and has a priority strictly greater than the threshold of context c.
- R6: A source whose priority is 0 is never delivered to any context and is never returned by a claim.
- R7: A threshold of 7 holds irq_o[c] low for every source. A threshold of 0 admits every source with a nonzero priority.
- R8: A claim read returns the deliverable source with the highest priority, with ties going to the lowest ID. It clears that source's pending flag, and the change is visible to all contexts.
- R9: A claimed source raises no new request until a completion write of its ID arrives. A completion write from a context for which that source is not enabled has no effect.
- R10: A level-triggered source that is still high after completion becomes pending again. An edge-triggered source (by default IDs 16 to 31) becomes pending only on a new rising edge. Edges seen while the source is in service are dropped.
- R11: Reads of addresses that map to no implemented register return 0, and writes to them change nothing.
- R12: bus_rvalid is high in the cycle after a read request and low in every other cycle, and bus_rdata is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC-1 | Interrupt request lines for IDs 1..NSRC-1, synchronous to clk |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| irq_o | output | NCTX | External interrupt request per context |

## Verification
Every priority and enable register is swept with write values that have junk in the unimplemented bits. This separates correct field masking and address decoding from aliasing. The arbitration is then driven with several source masks against a priority pattern that has duplicated values and a zero entry. The masks include all sources at once, a single tie pair, a lone zero-priority source, and a sparse set under nonzero thresholds. Comparing every claim in each drain sequence with an arithmetic model separates priority order, lowest-ID tie-breaking and threshold strictness. Separate sequences cover the following:
- a completion from a context where the source is not enabled,
- a level source that is held high across completion,
- an edge source that is re-pulsed while in service,
- threshold 7 against threshold 6.

These show whether the claim/complete handshake, rather than the raw line level, gates each new request.

// File: rtl/plic_pkg.sv
// Package: shared constants and types for the interrupt controller core.
// Assumes a byte-addressed 32-bit register bus whose addresses are word aligned.
package plic_pkg;
    localparam int           PRIO_W     = 3;
    localparam logic [31:0]  PRIO_END   = 32'h0000_1000;
    localparam logic [31:0]  EN_BASE    = 32'h0000_2000;
    localparam logic [31:0]  EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0]  CT_BASE    = 32'h0020_0000;
    localparam logic [31:0]  CT_STRIDE  = 32'h0000_1000;
    localparam logic [11:0]  OFF_THR    = 12'h000;
    localparam logic [11:0]  OFF_CLAIM  = 12'h004;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/plic_gateway.sv
// Module: one source gateway. It turns a raw request line into a pending flag
// and blocks further requests between a claim and the matching completion.
// Assumes src_i is synchronous to clk and that claim_i/complete_i are single-cycle pulses.
module plic_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);
    logic src_q;
    logic pend_q;
    logic busy_q;
    logic req;

    // Request detection: the level itself, or a rising edge of the line
    generate
        if (EDGE) begin : g_edge
            assign req = src_i & ~src_q;
        end else begin : g_level
            assign req = src_i;
        end
    endgenerate

    // Pending / in-service state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            src_q <= src_i;
            if (claim_i) begin
                pend_q <= 1'b0;
                busy_q <= 1'b1;
            end else begin
                if (!pend_q && !busy_q && req) pend_q <= 1'b1;
                if (complete_i) busy_q <= 1'b0;
            end
        end
    end

    assign pending_o = pend_q;

    // R9: a source in service never shows as pending
    assert_no_pend_in_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !pend_q);

    // R8: a claim only ever hits a pending source
    assert_claim_hits_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> pend_q);
endmodule

// File: rtl/plic_ctx_arb.sv
// Module: per-context selector. It picks the enabled pending source with the highest
// priority above the threshold, with ties to the lowest ID. The path is purely combinational.
// Assumes NSRC <= 2**IDW and that ID 0 is reserved (not in the vectors).
module plic_ctx_arb
    import plic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int IDW  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:1]        pend_i,
    input  logic [NSRC-1:1]        en_i,
    input  prio_t [NSRC-1:1]       prio_i,
    input  prio_t                  thr_i,
    output logic [IDW-1:0]         best_id_o,
    output logic                   irq_o
);
    prio_t best_p;

    // Linear scan: a strict compare keeps the lowest ID on a tie
    always_comb begin
        best_p    = thr_i;
        best_id_o = '0;
        for (int s = 1; s < NSRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[s] > best_p)) begin
                best_p    = prio_i[s];
                best_id_o = IDW'(s);
            end
        end
    end

    assign irq_o = (best_id_o != '0);

    // R7: the top threshold blocks every source
    assert_max_thr_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '1) |-> !irq_o);

    // R6: a zero-priority source never wins
    assert_zero_prio_never_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (prio_i[best_id_o] != '0));
endmodule

// File: rtl/plic_core.sv
// Module: top of the interrupt controller core. It holds the register file and the
// address decode, and instantiates one gateway per source and one selector per context.
// Assumes single-cycle bus requests and word-aligned addresses. Reads return next cycle.
module plic_core
    import plic_pkg::*;
#(
    parameter int              NSRC     = 32,
    parameter int              NCTX     = 2,
    parameter int              ADDR_W   = 26,
    parameter logic [NSRC-1:0] EDGE_SRC = {{(NSRC/2){1'b1}}, {(NSRC-NSRC/2){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:1]   src_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NCTX-1:0]   irq_o
);
    localparam int IDW   = (NSRC > 2) ? $clog2(NSRC) : 1;
    localparam int NWORD = (NSRC + 31) / 32;
    localparam int CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1;

    prio_t [NSRC-1:1]              prio_q;
    logic  [NCTX-1:0][NSRC-1:1]    en_q;
    prio_t [NCTX-1:0]              thr_q;
    logic  [NSRC-1:1]              pend;
    logic  [NSRC-1:1]              claim_vec;
    logic  [NSRC-1:1]              done_vec;
    logic  [NCTX-1:0][IDW-1:0]     best_id;

    logic [31:0]     a, en_off, ct_off, rd_mux;
    logic            rd_req, wr_req;
    logic            prio_hit, en_hit, ct_hit;
    logic [IDW-1:0]  prio_id;
    logic [CTXW-1:0] en_ctx, ct_ctx;
    logic [4:0]      en_word;
    logic [11:0]     ct_reg;
    logic            claim_rd, done_wr;

    // Address decode into the three register regions
    always_comb begin
        a        = 32'(bus_addr);
        rd_req   = bus_en & ~bus_we;
        wr_req   = bus_en & bus_we;
        en_off   = a - EN_BASE;
        ct_off   = a - CT_BASE;
        prio_hit = (a < PRIO_END) && ((a >> 2) < 32'(NSRC)) && ((a >> 2) != 32'd0);
        prio_id  = a[IDW+1:2];
        en_hit   = (a >= EN_BASE) && (en_off < 32'(NCTX) * EN_STRIDE)
                   && (32'(en_off[6:2]) < 32'(NWORD));
        en_ctx   = en_off[7 +: CTXW];
        en_word  = en_off[6:2];
        ct_hit   = (a >= CT_BASE) && (ct_off < 32'(NCTX) * CT_STRIDE);
        ct_ctx   = ct_off[12 +: CTXW];
        ct_reg   = ct_off[11:0];
        claim_rd = rd_req && ct_hit && (ct_reg == OFF_CLAIM);
        done_wr  = wr_req && ct_hit && (ct_reg == OFF_CLAIM);
    end

    // Register writes: priorities, enable bits, thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr_req) begin
            if (prio_hit) prio_q[prio_id] <= bus_wdata[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                for (int s = 1; s < NSRC; s++) begin
                    if (en_hit && en_ctx == CTXW'(c) && en_word == 5'(s / 32))
                        en_q[c][s] <= bus_wdata[s % 32];
                end
                if (ct_hit && ct_ctx == CTXW'(c) && ct_reg == OFF_THR)
                    thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // Read mux: unmapped addresses and unimplemented bits read 0
    always_comb begin
        rd_mux = '0;
        if (prio_hit) rd_mux = 32'(prio_q[prio_id]);
        if (en_hit) begin
            for (int s = 1; s < NSRC; s++) begin
                if (en_word == 5'(s / 32)) rd_mux[s % 32] = en_q[en_ctx][s];
            end
        end
        if (ct_hit && ct_reg == OFF_THR)   rd_mux = 32'(thr_q[ct_ctx]);
        if (ct_hit && ct_reg == OFF_CLAIM) rd_mux = 32'(best_id[ct_ctx]);
    end

    // Read response register, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) bus_rdata <= rd_mux;
        end
    end

    // Claim and completion pulses per source
    always_comb begin
        for (int s = 1; s < NSRC; s++) begin
            claim_vec[s] = claim_rd && (best_id[ct_ctx] == IDW'(s));
            done_vec[s]  = done_wr && (bus_wdata == 32'(s)) && en_q[ct_ctx][s];
        end
    end

    // One gateway per real source
    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_src
            plic_gateway #(.EDGE(EDGE_SRC[g])) u_gw (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_i      (src_i[g]),
                .claim_i    (claim_vec[g]),
                .complete_i (done_vec[g]),
                .pending_o  (pend[g])
            );
        end
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            plic_ctx_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
                .clk       (clk),
                .rst_n     (rst_n),
                .pend_i    (pend),
                .en_i      (en_q[c]),
                .prio_i    (prio_q),
                .thr_i     (thr_q[c]),
                .best_id_o (best_id[c]),
                .irq_o     (irq_o[c])
            );
        end
    endgenerate

    // R12: read data valid exactly one cycle after a read request
    assert_rvalid_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    assert_no_rvalid_without_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
endmodule

// File: tb/test_plic_core.sv
`timescale 1ns/1ps
module test_plic_core;
    localparam logic [31:0] CT0 = 32'h0020_0000;
    localparam logic [31:0] CT1 = 32'h0020_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] src = '0;
    logic        b_en = 1'b0, b_we = 1'b0;
    logic [25:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [1:0]  irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] model = '0;
    logic [31:0] claimed = '0;

    plic_core i_plic_core (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en(b_en), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
        .bus_rvalid(rvalid), .irq_o(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] adr, input logic [31:0] d);
        b_en = 1'b1; b_we = 1'b1; b_addr = adr[25:0]; b_wdata = d;
        @(posedge clk); @(negedge clk);
        b_en = 1'b0; b_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] adr, output logic [31:0] d);
        b_en = 1'b1; b_we = 1'b0; b_addr = adr[25:0];
        @(posedge clk); @(negedge clk);
        chk("R12 rvalid", 32'(rvalid), 32'd1);
        d = rdata;
        b_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic int pr(input int id);
        return (id * 5) % 8;
    endfunction

    function automatic int best(input int thr);
        int bp = thr, b = 0;
        for (int id = 1; id < 32; id++)
            if (model[id] && pr(id) > bp) begin bp = pr(id); b = id; end
        return b;
    endfunction

    // Claim repeatedly from context 0 until nothing is deliverable
    task automatic drain(input int thr);
        logic [31:0] r;
        for (int k = 0; k < 33; k++) begin
            int e;
            e = best(thr);
            chk("R5 irq0", 32'(irq[0]), 32'(e != 0));
            chk("R5 irq1 disabled ctx", 32'(irq[1]), 32'd0);
            bus_read(CT0 + 4, r);
            chk("R8 claim order", r, 32'(e));
            if (e == 0) break;
            model[e] = 1'b0;
            claimed[e] = 1'b1;
        end
    endtask

    task automatic round(input logic [15:0] mask, input int thr);
        bus_write(CT0, 32'(thr));
        src[15:1] = mask[15:1];
        wait_cyc(2);
        model[15:1] = model[15:1] | mask[15:1];
        drain(thr);
        bus_write(CT0, 32'd0);
        drain(0);
        src[15:1] = '0;
        for (int id = 1; id < 32; id++)
            if (claimed[id]) bus_write(CT0 + 4, 32'(id));
        claimed = '0;
        wait_cyc(2);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // reset state
        chk("R5 reset irq", 32'(irq), 32'd0);
        chk("R12 reset rvalid", 32'(rvalid), 32'd0);
        bus_read(CT0 + 4, r); chk("R1 claim empty", r, 0);
        wait_cyc(1); chk("R12 rvalid drops", 32'(rvalid), 32'd0);
        bus_read(CT0, r); chk("R4 thr reset", r, 0);

        // R2 priority sweep with junk upper bits
        for (int id = 0; id < 32; id++) bus_write(32'(4 * id), 32'hFFFF_FFF8 | 32'((id % 7) + 1));
        for (int id = 0; id < 32; id++) begin
            bus_read(32'(4 * id), r);
            chk(id == 0 ? "R1 prio id0" : "R2 prio", r, id == 0 ? 32'd0 : 32'((id % 7) + 1));
        end
        bus_read(32'h80, r); chk("R11 prio beyond range", r, 0);

        // R3 enable words
        bus_write(32'h2000, 32'hFFFF_FFFF);
        bus_write(32'h2080, 32'hA5A5_A5A5);
        bus_read(32'h2000, r); chk("R1 R3 ctx0 enable", r, 32'hFFFF_FFFE);
        bus_read(32'h2080, r); chk("R3 ctx1 enable", r, 32'hA5A5_A5A4);
        bus_read(32'h2004, r); chk("R11 enable word1", r, 0);
        bus_read(32'h2100, r); chk("R11 enable ctx2", r, 0);

        // R4 thresholds
        bus_write(CT1, 32'hFF);
        bus_read(CT1, r); chk("R4 thr ctx1", r, 7);
        bus_read(CT0 + 8, r); chk("R11 ctl gap", r, 0);
        bus_write(32'h3000, 32'hFFFF_FFFF);
        bus_write(32'h0020_2000, 32'hFFFF_FFFF);
        bus_read(32'h3000, r); chk("R11 unmapped", r, 0);
        bus_read(CT0, r); chk("R11 no alias thr", r, 0);

        // arbitration patterns
        for (int id = 1; id < 32; id++) bus_write(32'(4 * id), 32'(pr(id)));
        bus_write(32'h2080, 32'h0);
        round(16'hFFFE, 0);
        round(16'hFFFE, 4);
        round(16'h0202, 0);
        round(16'h0100, 0);   // R6: only prio-0 source
        chk("R6 prio0 no irq", 32'(irq), 32'd0);
        round(16'h0808, 0);
        round(16'h5554, 3);

        // R9 completion from a non-enabled context is ignored
        src[3] = 1'b1; wait_cyc(2);
        bus_read(CT0 + 4, r); chk("R8 claim src3", r, 3);
        bus_write(CT1 + 4, 32'd3);
        wait_cyc(2);
        chk("R9 no irq while in service", 32'(irq[0]), 32'd0);
        bus_read(CT0 + 4, r); chk("R9 foreign complete ignored", r, 0);
        bus_write(CT0 + 4, 32'd3);
        wait_cyc(2);
        chk("R10 level re-pends irq", 32'(irq[0]), 32'd1);
        bus_read(CT0 + 4, r); chk("R10 level re-pends", r, 3);
        src[3] = 1'b0;
        bus_write(CT0 + 4, 32'd3);
        wait_cyc(2);
        bus_read(CT0 + 4, r); chk("R10 level released", r, 0);

        // R10 edge source 20 (prio 4)
        src[20] = 1'b1; wait_cyc(1); src[20] = 1'b0; wait_cyc(2);
        chk("R10 edge irq", 32'(irq[0]), 32'd1);
        bus_read(CT0 + 4, r); chk("R10 edge claim", r, 20);
        src[20] = 1'b1; wait_cyc(1); src[20] = 1'b0; wait_cyc(2);
        bus_read(CT0 + 4, r); chk("R10 edge dropped in service", r, 0);
        bus_write(CT0 + 4, 32'd20);
        wait_cyc(2);
        chk("R10 edge no re-pend", 32'(irq[0]), 32'd0);
        src[20] = 1'b1; wait_cyc(1); src[20] = 1'b0; wait_cyc(2);
        bus_read(CT0 + 4, r); chk("R10 new edge", r, 20);
        bus_write(CT0 + 4, 32'd20);

        // R7 threshold limits on context 1 with source 11 (prio 7)
        bus_write(32'h2080, 32'h0000_0800);
        bus_write(CT1, 32'd7);
        src[11] = 1'b1; wait_cyc(2);
        chk("R7 thr7 blocks", 32'(irq[1]), 32'd0);
        chk("R5 ctx0 sees src11", 32'(irq[0]), 32'd1);
        bus_write(CT1, 32'd6);
        chk("R5 thr6 passes prio7", 32'(irq[1]), 32'd1);
        bus_write(CT1, 32'd0);
        chk("R7 thr0 passes", 32'(irq[1]), 32'd1);
        bus_read(CT1 + 4, r); chk("R8 ctx1 claim", r, 11);
        chk("R8 pending cleared for all", 32'(irq), 32'd0);
        src[11] = 1'b0;
        bus_write(CT1 + 4, 32'd11);
        wait_cyc(2);
        chk("R9 complete from ctx1", 32'(irq), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule